// File: doc/BRIEF.md
# Vector Element Step Controller

This block keeps the loop state that a scalar core with a vector extension needs in order to walk a vector one element at a time. The state is held in five fields: the vector length, the maximum vector length, a source element index, a destination element index and a vertical-first mode bit. Decoded commands arrive on a valid/opcode interface, one per cycle. The result and condition outputs are registered and appear one cycle after their command.

There are three commands. A set-length command loads both lengths and selects the mode, and it can return the new length as a result. A step command advances both indices when vertical-first mode is on. When the indices reach the vector length, they wrap to zero, the mode turns off and an end-of-loop bit is raised in an optional 4-bit condition field. A query command returns the current source or destination index and then moves on to the next element. Issued once per element, it produces an index sequence.

Top module: `vstep_ctrl`

## Requirements
- R1: A command with `cmd_valid_i`=1 and `cmd_op_i`=1 (set-length) writes `len_i` into both the vector length and the maximum length, and sets both indices to 0.
- R2: On a set-length command with `rt_req_i`=1, `res_valid_o` is 1 on the following cycle and `res_o` holds the new length, zero-extended. With `rt_req_i`=0, `res_valid_o` stays 0.
- R3: A set-length command copies `vf_i` into the mode bit. `vf_i`=1 sets the bit and `vf_i`=0 clears it.
- R4: A step command (`cmd_op_i`=2) issued while the mode bit is 1 raises the source and destination indices together by exactly one, as long as the new value stays below the vector length.
- R5: When a step would make the indices equal to the vector length, both indices become 0 and the mode bit clears. A length of 3 with two steps leaves the indices at 2 with the mode still on. A length of 2 with two steps leaves the indices at 0 with the mode off.
- R6: When `rc_i`=1 on a step or query command, `cr_valid_o` is 1 on the next cycle. `cr_o` bits 3, 2 and 1 (less, greater, equal) are 0. Bit 0 (overflow summary) is 1 exactly when that command reached the end of the loop.
- R7: With a vector length of 0, a step in vertical-first mode ends the loop at once: the indices stay at 0, the mode clears and bit 0 of the condition field is 1.
- R8: A step issued while the mode bit is 0 leaves every state field unchanged. If `rc_i`=1, it reports `cr_o`=0.
- R9: A query command (`cmd_op_i`=3) returns the source index (`sel_dst_i`=0) or the destination index (`sel_dst_i`=1) as read before the command. It then advances the indices in either mode, wrapping at the vector length. Over a length of 4 it returns 0, 1, 2, 3.
- R10: `rst_ni` low clears every state field and output to 0. Commands with `cmd_valid_i`=0, and opcode 0, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 none, 1 set-length, 2 step, 3 query |
| len_i | input | LEN_W | New length for set-length |
| vf_i | input | 1 | Mode value for set-length |
| rt_req_i | input | 1 | Return the length on set-length |
| rc_i | input | 1 | Request a condition update |
| sel_dst_i | input | 1 | Query selects the destination index |
| vl_o | output | LEN_W | Vector length |
| maxvl_o | output | LEN_W | Maximum vector length |
| src_idx_o | output | LEN_W | Source element index |
| dst_idx_o | output | LEN_W | Destination element index |
| vf_o | output | 1 | Vertical-first mode bit |
| res_valid_o | output | 1 | Result strobe |
| res_o | output | XLEN | Result value |
| cr_valid_o | output | 1 | Condition field strobe |
| cr_o | output | 4 | {less, greater, equal, overflow summary} |

## Verification
The bench goes after the last-element step. A design that compares the current index instead of the incremented one would take one step too many, either exposing an index equal to the length or never raising the end bit. Length 0 is tested because a design that only checks for equality would walk the index upward for ever. A step outside vertical-first mode is tested to catch a design that advances anyway or reports a stale end bit. The query sequence catches a design that returns the index after the increment, which would yield 1, 2, 3, 0 instead of 0, 1, 2, 3.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_SETLEN = 2'd1,
    OP_STEP   = 2'd2,
    OP_QUERY  = 2'd3
  } vstep_op_e;

  localparam int unsigned CR_W  = 4;
  localparam int unsigned CR_SO = 0;
endpackage

// File: rtl/vstep_dec.sv
module vstep_dec
  import vstep_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic       vf_mode_i,
  input  logic       rt_req_i,
  input  logic       rc_i,
  output logic       do_set_o,
  output logic       do_adv_o,
  output logic       set_res_o,
  output logic       qry_res_o,
  output logic       cr_req_o
);
  logic is_set, is_step, is_qry;

  always_comb begin
    is_set    = valid_i && (op_i == OP_SETLEN);
    is_step   = valid_i && (op_i == OP_STEP);
    is_qry    = valid_i && (op_i == OP_QUERY);
    do_set_o  = is_set;
    // step moves only in vertical-first mode; query always moves
    do_adv_o  = (is_step && vf_mode_i) || is_qry;
    set_res_o = is_set && rt_req_i;
    qry_res_o = is_qry;
    cr_req_o  = (is_step || is_qry) && rc_i;
  end
endmodule

// File: rtl/vstep_adv.sv
module vstep_adv #(
  parameter int unsigned LEN_W = 7
) (
  input  logic [LEN_W-1:0] idx_i,
  input  logic [LEN_W-1:0] vl_i,
  output logic [LEN_W-1:0] nxt_o,
  output logic             wrap_o
);
  logic [LEN_W:0] inc;

  always_comb begin
    inc    = {1'b0, idx_i} + (LEN_W+1)'(1);
    // >= so that a zero length ends on the first step
    wrap_o = (inc >= {1'b0, vl_i});
    nxt_o  = wrap_o ? '0 : inc[LEN_W-1:0];
  end
endmodule

// File: rtl/vstep_resp.sv
module vstep_resp
  import vstep_pkg::*;
#(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned XLEN  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_res_i,
  input  logic [LEN_W-1:0] set_val_i,
  input  logic             qry_res_i,
  input  logic [LEN_W-1:0] qry_val_i,
  input  logic             cr_req_i,
  input  logic             end_i,
  output logic             res_valid_o,
  output logic [XLEN-1:0]  res_o,
  output logic             cr_valid_o,
  output logic [CR_W-1:0]  cr_o
);
  localparam int unsigned PAD_W = XLEN - LEN_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
      cr_valid_o  <= 1'b0;
      cr_o        <= '0;
    end else begin
      res_valid_o <= set_res_i || qry_res_i;
      if (set_res_i)      res_o <= {{PAD_W{1'b0}}, set_val_i};
      else if (qry_res_i) res_o <= {{PAD_W{1'b0}}, qry_val_i};
      else                res_o <= '0;
      cr_valid_o <= cr_req_i;
      cr_o       <= '0;
      if (cr_req_i) cr_o[CR_SO] <= end_i;
    end
  end
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
#(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned XLEN  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             vf_i,
  input  logic             rt_req_i,
  input  logic             rc_i,
  input  logic             sel_dst_i,
  output logic [LEN_W-1:0] vl_o,
  output logic [LEN_W-1:0] maxvl_o,
  output logic [LEN_W-1:0] src_idx_o,
  output logic [LEN_W-1:0] dst_idx_o,
  output logic             vf_o,
  output logic             res_valid_o,
  output logic [XLEN-1:0]  res_o,
  output logic             cr_valid_o,
  output logic [3:0]       cr_o
);
  localparam int unsigned N_IDX = 2;

  logic do_set, do_adv, set_res, qry_res, cr_req;
  logic [LEN_W-1:0] idx_q [N_IDX];
  logic [LEN_W-1:0] idx_n [N_IDX];
  logic [N_IDX-1:0] wrap;
  logic [LEN_W-1:0] vl_q, maxvl_q;
  logic             vf_q;
  logic             end_hit;

  vstep_dec u_dec (
    .valid_i   (cmd_valid_i),
    .op_i      (cmd_op_i),
    .vf_mode_i (vf_q),
    .rt_req_i  (rt_req_i),
    .rc_i      (rc_i),
    .do_set_o  (do_set),
    .do_adv_o  (do_adv),
    .set_res_o (set_res),
    .qry_res_o (qry_res),
    .cr_req_o  (cr_req)
  );

  for (genvar g = 0; g < N_IDX; g++) begin : g_lane
    vstep_adv #(.LEN_W(LEN_W)) u_adv (
      .idx_i  (idx_q[g]),
      .vl_i   (vl_q),
      .nxt_o  (idx_n[g]),
      .wrap_o (wrap[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     idx_q[g] <= '0;
      else if (do_set) idx_q[g] <= '0;
      else if (do_adv) idx_q[g] <= idx_n[g];
    end
  end

  // indices move in lockstep; source lane decides the end
  assign end_hit = do_adv && wrap[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q    <= '0;
      maxvl_q <= '0;
      vf_q    <= 1'b0;
    end else if (do_set) begin
      vl_q    <= len_i;
      maxvl_q <= len_i;
      vf_q    <= vf_i;
    end else if (end_hit) begin
      vf_q    <= 1'b0;
    end
  end

  vstep_resp #(.LEN_W(LEN_W), .XLEN(XLEN)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_res_i   (set_res),
    .set_val_i   (len_i),
    .qry_res_i   (qry_res),
    .qry_val_i   (sel_dst_i ? idx_q[1] : idx_q[0]),
    .cr_req_i    (cr_req),
    .end_i       (end_hit),
    .res_valid_o (res_valid_o),
    .res_o       (res_o),
    .cr_valid_o  (cr_valid_o),
    .cr_o        (cr_o)
  );

  assign vl_o      = vl_q;
  assign maxvl_o   = maxvl_q;
  assign src_idx_o = idx_q[0];
  assign dst_idx_o = idx_q[1];
  assign vf_o      = vf_q;
endmodule

// File: rtl/vstep_ctrl_chk.sv
module vstep_ctrl_chk
  import vstep_pkg::*;
#(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned XLEN  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_op_i,
  input logic [LEN_W-1:0] len_i,
  input logic             vf_i,
  input logic             rt_req_i,
  input logic             rc_i,
  input logic             sel_dst_i,
  input logic [LEN_W-1:0] vl_o,
  input logic [LEN_W-1:0] maxvl_o,
  input logic [LEN_W-1:0] src_idx_o,
  input logic [LEN_W-1:0] dst_idx_o,
  input logic             vf_o,
  input logic             res_valid_o,
  input logic [XLEN-1:0]  res_o,
  input logic             cr_valid_o,
  input logic [3:0]       cr_o
);
  logic [LEN_W:0] src_inc;
  assign src_inc = {1'b0, src_idx_o} + (LEN_W+1)'(1);

  // R1
  set_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_SETLEN) |=>
      (vl_o == $past(len_i) && maxvl_o == $past(len_i) && src_idx_o == '0 && dst_idx_o == '0));

  // R3
  set_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_SETLEN) |=> (vf_o == $past(vf_i)));

  // R4
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_STEP && vf_o && src_inc < {1'b0, vl_o}) |=>
      (src_idx_o == LEN_W'($past(src_idx_o) + 1'b1) &&
       dst_idx_o == LEN_W'($past(dst_idx_o) + 1'b1) && vf_o));

  // R5
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_STEP && vf_o && src_inc >= {1'b0, vl_o}) |=>
      (src_idx_o == '0 && dst_idx_o == '0 && !vf_o));

  // R6
  cr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> (cr_o[3:1] == 3'b000));

  // R8
  step_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_STEP && !vf_o) |=>
      ($stable(src_idx_o) && $stable(dst_idx_o) && $stable(vl_o) && !vf_o &&
       cr_o == 4'b0000));

  // R10
  no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || cmd_op_i == OP_NOP) |=>
      ($stable(src_idx_o) && $stable(vl_o) && $stable(vf_o) && !res_valid_o && !cr_valid_o));

  // R2
  res_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (res_o == '0));
endmodule

bind vstep_ctrl vstep_ctrl_chk #(.LEN_W(LEN_W), .XLEN(XLEN)) u_chk (.*);

// File: tb/vstep_ctrl_bench.sv
module vstep_ctrl_bench;
  localparam int LEN_W = 7;
  localparam int XLEN  = 64;
  localparam int NV    = 16;

  typedef struct packed {
    logic [1:0]       op;
    logic [LEN_W-1:0] len;
    logic             vf;
    logic             rt;
    logic             rc;
    logic             sel;
    logic [LEN_W-1:0] e_vl;
    logic [LEN_W-1:0] e_src;
    logic [LEN_W-1:0] e_dst;
    logic             e_vf;
    logic             e_rv;
    logic [LEN_W-1:0] e_res;
    logic             e_cv;
    logic [3:0]       e_cr;
  } vec_t;

  // op len vf rt rc sel | vl src dst vf rv res cv cr
  localparam vec_t VEC [NV] = '{
    '{2'd1, 7'd3, 1'b1, 1'b1, 1'b0, 1'b0, 7'd3, 7'd0, 7'd0, 1'b1, 1'b1, 7'd3, 1'b0, 4'd0}, // R1 R2 R3
    '{2'd2, 7'd0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd3, 7'd1, 7'd1, 1'b1, 1'b0, 7'd0, 1'b1, 4'd0}, // R4 R6
    '{2'd2, 7'd0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd3, 7'd2, 7'd2, 1'b1, 1'b0, 7'd0, 1'b1, 4'd0}, // R5 len3
    '{2'd2, 7'd0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd3, 7'd0, 7'd0, 1'b0, 1'b0, 7'd0, 1'b1, 4'd1}, // R5 R6 end
    '{2'd2, 7'd0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd3, 7'd0, 7'd0, 1'b0, 1'b0, 7'd0, 1'b1, 4'd0}, // R8
    '{2'd1, 7'd2, 1'b1, 1'b0, 1'b0, 1'b0, 7'd2, 7'd0, 7'd0, 1'b1, 1'b0, 7'd0, 1'b0, 4'd0}, // R2 no result
    '{2'd2, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd2, 7'd1, 7'd1, 1'b1, 1'b0, 7'd0, 1'b0, 4'd0}, // R4
    '{2'd2, 7'd0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd2, 7'd0, 7'd0, 1'b0, 1'b0, 7'd0, 1'b1, 4'd1}, // R5 len2
    '{2'd1, 7'd4, 1'b0, 1'b1, 1'b0, 1'b0, 7'd4, 7'd0, 7'd0, 1'b0, 1'b1, 7'd4, 1'b0, 4'd0}, // R3 clear
    '{2'd3, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd4, 7'd1, 7'd1, 1'b0, 1'b1, 7'd0, 1'b0, 4'd0}, // R9
    '{2'd3, 7'd0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd4, 7'd2, 7'd2, 1'b0, 1'b1, 7'd1, 1'b0, 4'd0}, // R9
    '{2'd3, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd4, 7'd3, 7'd3, 1'b0, 1'b1, 7'd2, 1'b0, 4'd0}, // R9
    '{2'd3, 7'd0, 1'b0, 1'b0, 1'b1, 1'b1, 7'd4, 7'd0, 7'd0, 1'b0, 1'b1, 7'd3, 1'b1, 4'd1}, // R9 R6
    '{2'd1, 7'd0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0, 7'd0, 7'd0, 1'b1, 1'b1, 7'd0, 1'b0, 4'd0}, // R1 len0
    '{2'd2, 7'd0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 7'd0, 1'b1, 4'd1}, // R7
    '{2'd0, 7'd9, 1'b1, 1'b1, 1'b1, 1'b0, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 7'd0, 1'b0, 4'd0}  // R10 nop
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic [1:0]       cmd_op_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             vf_i = 1'b0, rt_req_i = 1'b0, rc_i = 1'b0, sel_dst_i = 1'b0;
  logic [LEN_W-1:0] vl_o, maxvl_o, src_idx_o, dst_idx_o;
  logic             vf_o, res_valid_o, cr_valid_o;
  logic [XLEN-1:0]  res_o;
  logic [3:0]       cr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vstep_ctrl #(.LEN_W(LEN_W), .XLEN(XLEN)) u_vstep_ctrl (.*);

  task automatic drive(input logic v, input logic [1:0] op, input logic [LEN_W-1:0] len,
                       input logic vf, input logic rt, input logic rc, input logic sel);
    cmd_valid_i = v; cmd_op_i = op; len_i = len;
    vf_i = vf; rt_req_i = rt; rc_i = rc; sel_dst_i = sel;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_state();
    return {res_o[15:0], 7'd0, vl_o, maxvl_o, src_idx_o, dst_idx_o,
            vf_o, res_valid_o, cr_valid_o, cr_o, 9'd0};
  endfunction

  function automatic logic [63:0] pack_exp(input logic [LEN_W-1:0] vl, input logic [LEN_W-1:0] s,
      input logic [LEN_W-1:0] d, input logic vf, input logic rv, input logic [LEN_W-1:0] r,
      input logic cv, input logic [3:0] cr);
    return {9'd0, r, 7'd0, vl, vl, s, d, vf, rv, cv, cr, 9'd0};
  endfunction

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 reset", pack_state(), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].op, VEC[i].len, VEC[i].vf, VEC[i].rt, VEC[i].rc, VEC[i].sel);
      @(negedge clk_i);
      check($sformatf("R%0s vec %0d", "x", i), pack_state(),
            pack_exp(VEC[i].e_vl, VEC[i].e_src, VEC[i].e_dst, VEC[i].e_vf, VEC[i].e_rv,
                     VEC[i].e_res, VEC[i].e_cv, VEC[i].e_cr));
    end

    // R10 valid low: a set-length with no strobe is ignored
    drive(1'b1, 2'd1, 7'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b1, 2'd2, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b0, 2'd1, 7'd9, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk_i);
    check("R10 no strobe", pack_state(), pack_exp(7'd5, 7'd1, 7'd1, 1'b1, 1'b0, 7'd0, 1'b0, 4'd0));

    // R4 long length: walk to the last element, then R5 wrap
    drive(1'b1, 2'd1, 7'd127, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b1, 2'd2, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (126) @(negedge clk_i);
    check("R4 idx 126", {57'd0, src_idx_o}, 64'd126);
    drive(1'b1, 2'd2, 7'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk_i);
    check("R5 wrap 127", pack_state(), pack_exp(7'd127, 7'd0, 7'd0, 1'b0, 1'b0, 7'd0, 1'b1, 4'd1));

    // R10 reset mid-run clears state
    drive(1'b1, 2'd1, 7'd6, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b0, 2'd0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R10 mid reset", pack_state(), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule